// File: doc/BRIEF.md
# Pipelined Burst Static Memory with Cycle Decoder

This block is a synchronous static memory with a registered read path. It is built for processor caches that fetch lines in four-word bursts. Every rising clock edge it samples three chip-select inputs, two address strobes, an advance input and the write controls. From these it classifies the clock as one of these cycle types:

- idle (sleep)
- deselect
- begin read
- begin write
- continue
- suspend

A burst starts at an external address. The next three accesses stay inside the same aligned group of four words. A static order input picks between two walks through that group: a wrapping increment, or an exclusive-or of the start offset with the beat count.

Writes land in the array at the same edge that samples the write data. A global write stores all four byte lanes. A byte write stores only the lanes whose select is low. Read data goes through an output register and appears one clock after the address was sampled. A combinational output enable then gates the data. The high-impedance pad is modelled as a zero data bus with a low valid flag.

Top module: `bsram_top`

## Requirements
- R1: The chip counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. With `strb_ctl_n` low and the chip not selected, the cycle is a deselect. It cancels any burst, and `rvalid` is low after the next clock edge.
- R2: With `strb_host_n` low while `sel_a_n` is high, and `strb_ctl_n` high, the host strobe has no effect. The clock acts as a continue (`step_n`=0) or a suspend (`step_n`=1) of the running burst.
- R3: With `strb_host_n` low and the chip selected, a read begins at `addr`, even when the write controls request a write.
- R4: With `strb_ctl_n` low, `strb_host_n` high and the chip selected, a write begins at `addr` if the cycle is a write (see R6); otherwise a read begins there. A write cycle never drives `rvalid`.
- R5: With both strobes high, `step_n`=0 moves to the next beat and `step_n`=1 repeats the current beat. The beat address keeps the upper bits of the start address. Its two low bits are (start+k) mod 4 when `order_xor`=0, and start XOR k when `order_xor`=1, where k is the beat count 0..3 (wrapping).
- R6: A cycle is a write when `wr_all_n`=0, or when `wr_byte_n`=0 with at least one `lane_n` bit low. `wr_all_n`=0 stores all lanes whatever `lane_n` holds. `lane_n[0]` guards bits 7:0, `lane_n[1]` bits 15:8, `lane_n[2]` bits 23:16 and `lane_n[3]` bits 31:24. Unselected lanes keep their contents.
- R7: For a read access sampled at edge N, the data stored at that address before edge N+1 appears on `rdata`, with `rvalid` high, after edge N+1.
- R8: `drive_n` acts without the clock. While it is high, `rvalid` is 0 and `rdata` is 0. When it falls, the registered data reappears at once.
- R9: While `nap` is high at an edge, no access is made and any burst is dropped. After `nap` falls, continue and suspend cycles make no access until a begin cycle. Array contents are kept.
- R10: While `rst_n` is low, `rvalid` is 0 and no burst is in progress.
- R11: Continue and suspend cycles keep the type of the burst that is running. In a write burst, each beat stores the lanes chosen by that cycle's own write controls, and nothing if none are chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Primary chip select, active low |
| sel_b | input | 1 | Expansion select, active high |
| sel_c_n | input | 1 | Expansion select, active low |
| strb_host_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Byte-lane selects, active low |
| order_xor | input | 1 | Burst order: 0 wrapping increment, 1 exclusive-or |
| nap | input | 1 | Sleep request, sampled on the clock |
| drive_n | input | 1 | Output enable, active low, combinational |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not driven |
| rvalid | output | 1 | Read data is being driven |

## Verification
A write is stored at the edge that samples it, so a read of that address issued at the very next edge already returns the new value. Read data and the valid flag come out one edge after the address edge. A deselect or nap drops the flag on that same one-edge delay. The output-enable gate acts within the same cycle and has no edge delay.

The bench keeps a behavioural reference that advances at each rising edge. It compares `rvalid` and `rdata` at every falling edge, so each result is sampled half a clock after the edge that is due to produce it. Directed checks of burst order, byte merging and sleep recovery are placed using the same one-edge offset. The output-enable check samples a nanosecond after toggling `drive_n`, with no edge in between.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_BEGIN_RD,
    CYC_BEGIN_WR,
    CYC_CONT,
    CYC_SUSP
  } cyc_e;

  typedef enum logic [1:0] {
    BOP_NONE,
    BOP_RD,
    BOP_WR
  } bop_e;

  // Low two address bits of beat 'step' of a burst starting at 'start'.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       xor_order);
    logic [1:0] r;
    if (xor_order) r = start ^ step;
    else           r = start + step;
    return r;
  endfunction

endpackage

// File: rtl/bsram_cycle_dec.sv
module bsram_cycle_dec
  import bsram_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              strb_host_n,
  input  logic              strb_ctl_n,
  input  logic              step_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [NBYTES-1:0] lane_n,
  input  logic              nap,
  output cyc_e              cyc,
  output logic [NBYTES-1:0] wmask,
  output logic              is_write
);

  logic chip_on;

  assign chip_on = !sel_a_n && sel_b && !sel_c_n;

  // Per-lane write enables; global write forces every lane.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign wmask[b] = !wr_all_n || (!wr_byte_n && !lane_n[b]);
  end

  assign is_write = |wmask;

  // Priority: sleep, host strobe (only when primary select active),
  // controller strobe, then advance/hold.
  always_comb begin
    if (nap)                               cyc = CYC_IDLE;
    else if (!strb_host_n && !sel_a_n)     cyc = chip_on ? CYC_BEGIN_RD : CYC_DESEL;
    else if (!strb_ctl_n) begin
      if (!chip_on)                        cyc = CYC_DESEL;
      else if (is_write)                   cyc = CYC_BEGIN_WR;
      else                                 cyc = CYC_BEGIN_RD;
    end
    else if (!step_n)                      cyc = CYC_CONT;
    else                                   cyc = CYC_SUSP;
  end

endmodule

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          cyc,
  input  logic [AW-1:0] addr,
  input  logic          order_xor,
  output logic [AW-1:0] acc_addr,
  output logic          acc_rd,
  output logic          acc_wr,
  output bop_e          op
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    step_c;
  bop_e          op_q;

  assign op = op_q;

  always_comb begin
    acc_rd   = 1'b0;
    acc_wr   = 1'b0;
    acc_addr = addr;
    step_c   = cnt_q;
    case (cyc)
      CYC_BEGIN_RD: acc_rd = 1'b1;
      CYC_BEGIN_WR: acc_wr = 1'b1;
      CYC_CONT, CYC_SUSP: begin
        step_c   = (cyc == CYC_CONT) ? cnt_q + 2'd1 : cnt_q;
        acc_addr = {base_q[AW-1:2], burst_lo(base_q[1:0], step_c, order_xor)};
        acc_rd   = (op_q == BOP_RD);
        acc_wr   = (op_q == BOP_WR);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= BOP_NONE;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (cyc)
        CYC_BEGIN_RD: begin op_q <= BOP_RD; base_q <= addr; cnt_q <= '0; end
        CYC_BEGIN_WR: begin op_q <= BOP_WR; base_q <= addr; cnt_q <= '0; end
        CYC_CONT:     if (op_q != BOP_NONE) cnt_q <= step_c;
        CYC_DESEL, CYC_IDLE: op_q <= BOP_NONE;
        default: ;
      endcase
    end
  end

  // R5: advancing or holding never moves the burst's start address.
  assert_base_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_CONT || cyc == CYC_SUSP) |=> (base_q == $past(base_q)));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int AW     = 6,
  parameter int DW     = 32,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [NBYTES-1:0] wmask,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     dout,
  output logic              dval
);

  localparam int DEPTH  = 1 << AW;
  localparam int LANE_W = DW / NBYTES;

  logic          rd_pend_q;
  logic [AW-1:0] rd_addr_q;
  logic          dval_q;

  // Stage 1: register the read request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      dval_q    <= 1'b0;
    end else begin
      rd_pend_q <= acc_rd;
      rd_addr_q <= acc_addr;
      dval_q    <= rd_pend_q;
    end
  end

  assign dval = dval_q;

  // One storage column per byte lane; stage 2 fills the output register.
  for (genvar b = 0; b < NBYTES; b++) begin : g_col
    logic [LANE_W-1:0] col_mem [DEPTH];
    logic [LANE_W-1:0] col_q;

    always_ff @(posedge clk) begin
      if (acc_wr && wmask[b]) col_mem[acc_addr] <= wdata[b*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         col_q <= '0;
      else if (rd_pend_q) col_q <= col_mem[rd_addr_q];
    end

    assign dout[b*LANE_W +: LANE_W] = col_q;
  end

  // R4: a write access never schedules output data.
  assert_wr_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !rd_pend_q);

endmodule

// File: rtl/bsram_top.sv
module bsram_top
  import bsram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int DW     = 32,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              strb_host_n,
  input  logic              strb_ctl_n,
  input  logic              step_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [NBYTES-1:0] lane_n,
  input  logic              order_xor,
  input  logic              nap,
  input  logic              drive_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);

  cyc_e              cyc;
  logic [NBYTES-1:0] wmask;
  logic              is_write;
  logic [AW-1:0]     acc_addr;
  logic              acc_rd;
  logic              acc_wr;
  bop_e              burst_op;
  logic [DW-1:0]     dout;
  logic              dval;

  // Named events for the assertions.
  logic ev_desel, ev_begin_rd, ev_host_ignored;
  assign ev_desel        = (cyc == CYC_DESEL);
  assign ev_begin_rd     = (cyc == CYC_BEGIN_RD);
  assign ev_host_ignored = !nap && !strb_host_n && sel_a_n && strb_ctl_n;

  bsram_cycle_dec #(.NBYTES(NBYTES)) u_dec (
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .nap(nap),
    .cyc(cyc), .wmask(wmask), .is_write(is_write)
  );

  bsram_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .addr(addr), .order_xor(order_xor),
    .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr), .op(burst_op)
  );

  bsram_array #(.AW(AW), .DW(DW), .NBYTES(NBYTES)) u_arr (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .wmask(wmask),
    .acc_addr(acc_addr), .wdata(wdata), .dout(dout), .dval(dval)
  );

  // Combinational output enable in front of the registered data.
  assign rvalid = dval && !drive_n;
  assign rdata  = rvalid ? dout : '0;

  // R1: a deselect turns the output off one edge later.
  assert_desel_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> ##1 !dval);

  // R7: a begun read yields data after the following edge.
  assert_read_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_begin_rd |=> ##1 dval);

  // R9: no array access while sleeping.
  assert_nap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nap |-> (!acc_rd && !acc_wr));

  // R2: an ignored host strobe never starts or ends a burst.
  assert_host_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_host_ignored |-> (cyc == CYC_CONT || cyc == CYC_SUSP));

  // R11: beats of a running write burst never read.
  assert_wr_burst_type_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_op == BOP_WR && (cyc == CYC_CONT || cyc == CYC_SUSP)) |-> !acc_rd);

endmodule

// File: tb/tb_bsram_top.sv
`timescale 1ns/100ps
module tb_bsram_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
  logic        strb_host_n = 1'b1, strb_ctl_n = 1'b1, step_n = 1'b1;
  logic        wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [3:0]  lane_n = 4'hF;
  logic        order_xor = 1'b0, nap = 1'b0, drive_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  int    n_tests = 0, n_fail = 0, n_cyc = 0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  bsram_top dut (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .order_xor(order_xor), .nap(nap), .drive_n(drive_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  // ---------------- reference model ----------------
  logic [31:0] mm [64];
  bit          m_pend, m_valid;
  int          m_paddr;
  logic [31:0] m_data;
  int          m_op, m_base, m_cnt;  // op: 0 none, 1 read, 2 write
  int          k_addr, k_lo;
  bit          k_rd, k_wr, k_sel, k_isw;
  logic [3:0]  k_mask;

  function automatic logic [31:0] pat(int a);
    return 32'hC0DE_0000 + a * 32'h0001_0101;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_valid = 0; m_paddr = 0; m_data = '0; m_op = 0; m_base = 0; m_cnt = 0;
    end else begin
      m_valid = m_pend;
      m_data  = mm[m_paddr];
      k_rd = 0; k_wr = 0; k_addr = addr;
      k_sel  = (sel_a_n == 0) && (sel_b == 1) && (sel_c_n == 0);
      k_mask = (wr_all_n == 0) ? 4'hF : ((wr_byte_n == 0) ? ~lane_n : 4'h0);
      k_isw  = (k_mask != 0);
      if (nap) m_op = 0;
      else if (!strb_host_n && !sel_a_n) begin
        if (k_sel) begin k_rd = 1; m_op = 1; m_base = addr; m_cnt = 0; end
        else m_op = 0;
      end else if (!strb_ctl_n) begin
        if (!k_sel) m_op = 0;
        else begin
          m_op = k_isw ? 2 : 1; m_base = addr; m_cnt = 0;
          k_rd = !k_isw; k_wr = k_isw;
        end
      end else if (m_op != 0) begin
        if (!step_n) m_cnt = (m_cnt + 1) % 4;
        k_lo   = order_xor ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
        k_addr = (m_base / 4) * 4 + k_lo;
        k_rd = (m_op == 1); k_wr = (m_op == 2);
      end
      if (k_wr)
        for (int b = 0; b < 4; b++)
          if (k_mask[b]) mm[k_addr][b*8 +: 8] = wdata[b*8 +: 8];
      m_pend = k_rd; m_paddr = k_addr;
    end
  end

  // Every-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (rvalid !== (m_valid && !drive_n) ||
          rdata !== ((m_valid && !drive_n) ? m_data : 32'h0)) begin
        n_fail++;
        $display("FAIL %s cycle: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                 tag, rvalid, rdata, m_valid && !drive_n,
                 (m_valid && !drive_n) ? m_data : 32'h0);
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", n_cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle_in();
    sel_a_n = 1; sel_b = 1; sel_c_n = 0; strb_host_n = 1; strb_ctl_n = 1;
    step_n = 1; wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; nap = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #0.5;
    idle_in();
  endtask

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic host_read(int a);
    sel_a_n = 0; strb_host_n = 0; addr = a[5:0];
    tick();
  endtask

  task automatic advance(bit hold);
    step_n = hold; tick();
  endtask

  task automatic ctl_write(int a, logic [31:0] d, bit all, logic [3:0] ln);
    sel_a_n = 0; strb_ctl_n = 0; addr = a[5:0]; wdata = d;
    wr_all_n = !all; wr_byte_n = all; lane_n = ln;
    tick();
  endtask

  // ---------------- sequence ----------------
  initial begin
    idle_in();
    repeat (3) @(negedge clk);
    chk("R10 reset rvalid", {31'h0, rvalid}, 32'h0);
    chk("R10 reset rdata", rdata, 32'h0);
    #0.5 rst_n = 1;
    tick();

    tag = "R6";
    for (int a = 0; a < 64; a++) ctl_write(a, pat(a), 1'b1, 4'hF);
    tick();

    // R3 + R5 wrapping increment from offset 2 with write inputs asserted.
    tag = "R3";
    order_xor = 0;
    wr_all_n = 0; host_read(6);
    tag = "R5";
    advance(0); chk("R3 begin data", rdata, pat(6));
    advance(0); chk("R5 linear beat1", rdata, pat(7));
    advance(0); chk("R5 linear beat2", rdata, pat(4));
    advance(1); chk("R5 linear beat3", rdata, pat(5));
    tick();     chk("R5 suspend repeats", rdata, pat(5));
    tick();

    // R5 exclusive-or order from offset 1; R2 ignored host strobe.
    order_xor = 1;
    host_read(13);
    advance(0); chk("R7 latency data", rdata, pat(13));
    tag = "R2";
    sel_a_n = 1; strb_host_n = 0; addr = 6'd40; step_n = 0; tick();
    chk("R5 xor beat1", rdata, pat(12));
    advance(0); chk("R2 host ignored beat2", rdata, pat(15));
    advance(0); chk("R5 xor beat3", rdata, pat(14));
    tick();

    // R8 async output enable.
    tag = "R8";
    host_read(20);
    advance(1);
    #0.5 drive_n = 1; #1;
    chk("R8 gated rvalid", {31'h0, rvalid}, 32'h0);
    chk("R8 gated rdata", rdata, 32'h0);
    drive_n = 0; #0.5;
    chk("R8 released rdata", rdata, pat(20));
    tick();

    // R6 byte lanes, R11 write burst beats.
    tag = "R6";
    order_xor = 0;
    ctl_write(9, 32'h1122_3344, 1'b0, 4'b1010);
    host_read(9); tick();
    chk("R6 lane merge", rdata, (pat(9) & 32'hFF00_FF00) | 32'h0022_0044);
    tag = "R11";
    ctl_write(16, 32'hAAAA_AAAA, 1'b1, 4'hF);
    step_n = 0; wdata = 32'h5555_5555; wr_byte_n = 0; lane_n = 4'b0111; tick();
    step_n = 0; wdata = 32'h7777_7777; tick();  // no write controls
    wr_all_n = 0; lane_n = 4'hF; step_n = 1; wdata = 32'h9999_9999; tick();
    host_read(17); tick();
    chk("R11 beat byte write", rdata, (pat(17) & 32'h00FF_FFFF) | 32'h5500_0000);
    host_read(18); tick();
    chk("R11 beat without write", rdata, 32'h9999_9999);
    host_read(16); tick();
    chk("R6 global override", rdata, 32'hAAAA_AAAA);
    tag = "R4";
    sel_a_n = 0; strb_ctl_n = 0; addr = 6'd30; wr_byte_n = 0; lane_n = 4'hF; tick();
    tick(); chk("R4 no-lane byte write is a read", rdata, pat(30));

    // R1 deselects.
    tag = "R1";
    host_read(33); advance(0);
    sel_a_n = 0; sel_b = 0; strb_ctl_n = 0; tick();
    tick(); chk("R1 valid drops", {31'h0, rvalid}, 32'h0);
    advance(0); chk("R1 burst cancelled", {31'h0, rvalid}, 32'h0);
    sel_a_n = 0; sel_c_n = 1; strb_host_n = 0; tick(); tick();

    // R9 sleep.
    tag = "R9";
    host_read(44); advance(0);
    nap = 1; tick(); tick();
    advance(0); advance(0);
    chk("R9 idle after wake", {31'h0, rvalid}, 32'h0);
    host_read(44); tick();
    chk("R9 contents kept", rdata, pat(44));

    // Mixed traffic against the reference model.
    tag = "R4";
    for (int i = 0; i < 2000; i++) begin
      if (i % 500 == 0) order_xor = $urandom % 2;
      sel_a_n = ($urandom % 4 == 0); sel_b = ($urandom % 5 != 0);
      sel_c_n = ($urandom % 5 == 0);
      strb_host_n = ($urandom % 4 != 0); strb_ctl_n = ($urandom % 3 != 0);
      step_n = $urandom % 2; wr_all_n = ($urandom % 4 != 0);
      wr_byte_n = $urandom % 2; lane_n = $urandom;
      nap = ($urandom % 16 == 0); drive_n = ($urandom % 8 == 0);
      addr = $urandom; wdata = $urandom;
      @(posedge clk); @(negedge clk); #0.5;
    end
    drive_n = 0; idle_in(); tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule